// File: doc/BRIEF.md
# Cache-Cluster Performance Counter Bank

This block counts activity inside a cache cluster. It holds a bank of 32-bit event counters and one free-running 64-bit cycle counter. A word-addressed register port with a 64-bit data path reaches all of them. Each event counter follows one single-cycle pulse input. Which hardware event drives each pulse is chosen by a separate selector block. That block decodes the per-counter type word that this bank stores and drives out on `evt_select`.

Three 32-bit bitmaps govern the counters: counting enables, interrupt enables and pending overflows. Event counter i owns bit i of each bitmap, and the cycle counter always owns bit 31. Software never writes a bitmap directly. Each bitmap has one address that sets the bits written as 1 and a second address that clears them, so several agents can change single bits without a read-modify-write. An overflow raises a level interrupt until software acknowledges it. To acknowledge, software reads the pending word and writes that same word to the clear address.

Software may preload any counter with a start value. It can zero the event counters and the cycle counter separately through strobe bits in the control word. A global enable bit in the control word gates all counting.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter, bitmap and configuration word is zero, `irq` is low, and the control word at 0x400 reads the event-counter count in bits [15:11] with bit 0 (global enable) clear.
- R2: An event counter advances by one on a clock edge only when global enable (control bit 0), its own enable bit and its pulse input are all 1 in that cycle.
- R3: The 64-bit cycle counter (read and written at 0x40A) advances by one on every clock edge while global enable and enable bit 31 are both set.
- R4: Writing to 0x404 / 0x406 sets, and writing to 0x403 / 0x405 clears, exactly the 1-bits of the written word in the counting-enable / interrupt-enable bitmap. Both addresses of a pair read the bitmap. Bits with no counter behind them read 0.
- R5: An event counter that steps from 0xFFFFFFFF to 0 sets its overflow bit on that same edge. The cycle counter wrapping from all-ones to 0 sets overflow bit 31.
- R6: Reading 0x408 returns the pending overflow bits, and writing to 0x408 sets bits. Writing a word to 0x407 clears exactly its 1-bits. A wrap in the same cycle as a clear of its bit leaves the bit set.
- R7: `irq` is high exactly while some overflow bit is set together with the same interrupt-enable bit.
- R8: A write to the control word loads global enable from bit 0. Bit 1 zeroes all event counters and bit 2 zeroes the cycle counter. Bits 1 and 2 always read 0.
- R9: A write to a count address (0x421 + 0x10·i for event counter i, 0x40A for the cycle counter) loads that value, and the value takes precedence over an increment in the same cycle.
- R10: Per event counter i, the control word (0x420 + 0x10·i), the filter word (0x423 + 0x10·i) and the type word (0x424 + 0x10·i) read back as written. The cycle-control word at 0x409 does the same. The type word of counter i appears on `evt_select[32·i +: 32]`.
- R11: Unmapped addresses read 0, and writes to them change no state. This includes per-counter slots beyond the configured count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 12 | Word address for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, same cycle |
| evt_pulse | input | NUM_EVT | One-cycle event pulses, bit i feeds counter i |
| evt_select | output | 32·NUM_EVT | Stored type word of each event counter |
| irq | output | 1 | Level overflow interrupt |

## Verification
A corrupted bitmap shows up on the next read of either address of its pair. It also shows through `irq` in the same cycle as the bad bit, because the interrupt is formed from registered state alone. A counter that steps when it should not, or misses a step, shows a value that is off by one on the next read. A missed or early wrap shows as a wrong overflow word read straight after the wrapping edge. The cases where two updates meet on the same edge are driven on exactly that edge: a clear racing a wrap, and a preload racing an increment.

// File: rtl/perf_bank_pkg.sv
package perf_bank_pkg;

  localparam int MAP_W    = 32;
  localparam int EVT_W    = 32;
  localparam int CYC_W    = 64;
  localparam int CYC_BIT  = 31;
  localparam int MAX_EVT  = 8;

  localparam logic [11:0] A_CTRL    = 12'h400;
  localparam logic [11:0] A_EN_CLR  = 12'h403;
  localparam logic [11:0] A_EN_SET  = 12'h404;
  localparam logic [11:0] A_IE_CLR  = 12'h405;
  localparam logic [11:0] A_IE_SET  = 12'h406;
  localparam logic [11:0] A_OV_CLR  = 12'h407;
  localparam logic [11:0] A_OV_SET  = 12'h408;
  localparam logic [11:0] A_CYC_CTL = 12'h409;
  localparam logic [11:0] A_CYC_CNT = 12'h40A;

  // per-counter window: 0x4S0..0x4SF, S = slot + 2
  localparam logic [3:0] WIN_PAGE  = 4'h4;
  localparam logic [3:0] WIN_FIRST = 4'h2;
  localparam logic [3:0] SUB_CTL   = 4'h0;
  localparam logic [3:0] SUB_CNT   = 4'h1;
  localparam logic [3:0] SUB_FLT   = 4'h3;
  localparam logic [3:0] SUB_TYP   = 4'h4;

  typedef struct packed {
    logic ctl;
    logic flt;
    logic typ;
    logic cnt;
  } slot_we_t;

  function automatic logic [MAP_W-1:0] map_mask(int n);
    logic [MAP_W-1:0] m;
    m = '0;
    for (int k = 0; k < MAP_W; k++) begin
      if (k < n) m[k] = 1'b1;
    end
    m[CYC_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/perf_bitmap_reg.sv
module perf_bitmap_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;
  logic         q_ce;
  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;

  always_comb begin
    set_bits = set_we ? wdata : '0;
    clr_bits = clr_we ? wdata : '0;
    // hardware set overrides a software clear on the same edge
    q_nxt    = (((q | set_bits) & ~clr_bits) | hw_set) & MASK;
    q_ce     = set_we | clr_we | (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_ce) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);

  logic [W-1:0] q_nxt;
  logic         q_ce;

  always_comb begin
    q_ce = zero | load | inc;
    wrap = inc & ~zero & ~load & (&q);
    if (zero) begin
      q_nxt = '0;
    end else if (load) begin
      q_nxt = load_val;
    end else begin
      q_nxt = q + {{(W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_ce) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/perf_slot_cfg.sv
module perf_slot_cfg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_ctl,
  input  logic         we_flt,
  input  logic         we_typ,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctl_q,
  output logic [W-1:0] flt_q,
  output logic [W-1:0] typ_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (we_ctl) begin
      ctl_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= '0;
    end else if (we_flt) begin
      flt_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ_q <= '0;
    end else if (we_typ) begin
      typ_q <= wdata;
    end
  end

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perf_bank_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [11:0]              reg_addr,
  input  logic [63:0]              reg_wdata,
  output logic [63:0]              reg_rdata,
  input  logic [NUM_EVT-1:0]       evt_pulse,
  output logic [NUM_EVT*EVT_W-1:0] evt_select,
  output logic                     irq
);

  localparam logic [MAP_W-1:0] MASK = map_mask(NUM_EVT);
  localparam logic [4:0]       NUM_FIELD = 5'(NUM_EVT);

  // ---------------- address decode ----------------
  logic [3:0] slot;
  logic [3:0] sub;
  logic       in_window;
  logic       wr_ctrl, wr_en_set, wr_en_clr, wr_ie_set, wr_ie_clr;
  logic       wr_ov_set, wr_ov_clr, wr_cyc_ctl, wr_cyc_cnt;

  always_comb begin
    slot      = reg_addr[7:4] - WIN_FIRST;
    sub       = reg_addr[3:0];
    in_window = (reg_addr[11:8] == WIN_PAGE) && (reg_addr[7:4] >= WIN_FIRST)
                && (int'(slot) < NUM_EVT);
    wr_ctrl    = reg_wr && (reg_addr == A_CTRL);
    wr_en_set  = reg_wr && (reg_addr == A_EN_SET);
    wr_en_clr  = reg_wr && (reg_addr == A_EN_CLR);
    wr_ie_set  = reg_wr && (reg_addr == A_IE_SET);
    wr_ie_clr  = reg_wr && (reg_addr == A_IE_CLR);
    wr_ov_set  = reg_wr && (reg_addr == A_OV_SET);
    wr_ov_clr  = reg_wr && (reg_addr == A_OV_CLR);
    wr_cyc_ctl = reg_wr && (reg_addr == A_CYC_CTL);
    wr_cyc_cnt = reg_wr && (reg_addr == A_CYC_CNT);
  end

  // ---------------- control word ----------------
  logic gen_en_q;
  logic gen_en_nxt;
  logic zero_evt;
  logic zero_cyc;
  logic [31:0] cyc_ctl_q;

  always_comb begin
    gen_en_nxt = reg_wdata[0];
    zero_evt   = wr_ctrl & reg_wdata[1];
    zero_cyc   = wr_ctrl & reg_wdata[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      gen_en_q <= gen_en_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_ctl_q <= '0;
    end else if (wr_cyc_ctl) begin
      cyc_ctl_q <= reg_wdata[31:0];
    end
  end

  // ---------------- bitmaps ----------------
  logic [MAP_W-1:0] en_q;
  logic [MAP_W-1:0] ie_q;
  logic [MAP_W-1:0] ovf_q;
  logic [MAP_W-1:0] ovf_hw;

  perf_bitmap_reg #(.W(MAP_W), .MASK(MASK)) u_en_map (
    .clk(clk), .rst_n(rst_n), .set_we(wr_en_set), .clr_we(wr_en_clr),
    .wdata(reg_wdata[MAP_W-1:0]), .hw_set('0), .q(en_q)
  );

  perf_bitmap_reg #(.W(MAP_W), .MASK(MASK)) u_ie_map (
    .clk(clk), .rst_n(rst_n), .set_we(wr_ie_set), .clr_we(wr_ie_clr),
    .wdata(reg_wdata[MAP_W-1:0]), .hw_set('0), .q(ie_q)
  );

  perf_bitmap_reg #(.W(MAP_W), .MASK(MASK)) u_ovf_map (
    .clk(clk), .rst_n(rst_n), .set_we(wr_ov_set), .clr_we(wr_ov_clr),
    .wdata(reg_wdata[MAP_W-1:0]), .hw_set(ovf_hw), .q(ovf_q)
  );

  // ---------------- counters ----------------
  logic [NUM_EVT*EVT_W-1:0] evt_cnt_flat;
  logic [NUM_EVT*EVT_W-1:0] ctl_flat;
  logic [NUM_EVT*EVT_W-1:0] flt_flat;
  logic [NUM_EVT-1:0]       evt_wrap;
  slot_we_t                 slot_we [NUM_EVT];

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    logic hit;
    logic inc;

    always_comb begin
      hit            = reg_wr && in_window && (slot == 4'(i));
      slot_we[i].ctl = hit && (sub == SUB_CTL);
      slot_we[i].cnt = hit && (sub == SUB_CNT);
      slot_we[i].flt = hit && (sub == SUB_FLT);
      slot_we[i].typ = hit && (sub == SUB_TYP);
      inc            = gen_en_q & en_q[i] & evt_pulse[i];
    end

    perf_counter #(.W(EVT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .zero(zero_evt), .load(slot_we[i].cnt),
      .load_val(reg_wdata[EVT_W-1:0]), .inc(inc),
      .q(evt_cnt_flat[i*EVT_W +: EVT_W]), .wrap(evt_wrap[i])
    );

    perf_slot_cfg #(.W(EVT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we_ctl(slot_we[i].ctl),
      .we_flt(slot_we[i].flt), .we_typ(slot_we[i].typ),
      .wdata(reg_wdata[EVT_W-1:0]),
      .ctl_q(ctl_flat[i*EVT_W +: EVT_W]),
      .flt_q(flt_flat[i*EVT_W +: EVT_W]),
      .typ_q(evt_select[i*EVT_W +: EVT_W])
    );
  end

  logic [CYC_W-1:0] cyc_q;
  logic             cyc_wrap;
  logic             cyc_inc;

  always_comb cyc_inc = gen_en_q & en_q[CYC_BIT];

  perf_counter #(.W(CYC_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .zero(zero_cyc), .load(wr_cyc_cnt),
    .load_val(reg_wdata), .inc(cyc_inc), .q(cyc_q), .wrap(cyc_wrap)
  );

  always_comb begin
    ovf_hw = '0;
    ovf_hw[NUM_EVT-1:0] = evt_wrap;
    ovf_hw[CYC_BIT]     = cyc_wrap;
  end

  // ---------------- interrupt ----------------
  always_comb irq = |(ovf_q & ie_q);

  // ---------------- read path ----------------
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[15:11] = NUM_FIELD;
        reg_rdata[0]     = gen_en_q;
      end
      A_EN_CLR, A_EN_SET: reg_rdata[MAP_W-1:0] = en_q;
      A_IE_CLR, A_IE_SET: reg_rdata[MAP_W-1:0] = ie_q;
      A_OV_CLR, A_OV_SET: reg_rdata[MAP_W-1:0] = ovf_q;
      A_CYC_CTL:          reg_rdata[31:0]      = cyc_ctl_q;
      A_CYC_CNT:          reg_rdata            = cyc_q;
      default: begin
        if (in_window) begin
          for (int i = 0; i < NUM_EVT; i++) begin
            if (slot == 4'(i)) begin
              unique case (sub)
                SUB_CTL: reg_rdata[EVT_W-1:0] = ctl_flat[i*EVT_W +: EVT_W];
                SUB_CNT: reg_rdata[EVT_W-1:0] = evt_cnt_flat[i*EVT_W +: EVT_W];
                SUB_FLT: reg_rdata[EVT_W-1:0] = flt_flat[i*EVT_W +: EVT_W];
                SUB_TYP: reg_rdata[EVT_W-1:0] = evt_select[i*EVT_W +: EVT_W];
                default: reg_rdata = '0;
              endcase
            end
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk
  import perf_bank_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [11:0]              reg_addr,
  input logic [63:0]              reg_wdata,
  input logic [NUM_EVT-1:0]       evt_pulse,
  input logic                     irq,
  input logic                     gen_en_q,
  input logic [MAP_W-1:0]         en_q,
  input logic [MAP_W-1:0]         ovf_q,
  input logic [MAP_W-1:0]         ovf_hw,
  input logic [NUM_EVT*EVT_W-1:0] evt_cnt_flat,
  input logic [CYC_W-1:0]         cyc_q
);

  // R2: with global enable off and no register write, nothing counts
  a_r2_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en_q && !reg_wr) |=> ($stable(evt_cnt_flat) && $stable(cyc_q)));

  // R3: cycle counter steps by exactly one while enabled
  a_r3_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en_q && en_q[CYC_BIT] && !reg_wr) |=> (cyc_q == $past(cyc_q) + 64'd1));

  // R5: a wrapping event counter leaves its overflow bit set
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_wrap
    a_r5_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_en_q && en_q[i] && evt_pulse[i] && !reg_wr &&
       (evt_cnt_flat[i*EVT_W +: EVT_W] == '1)) |=> ovf_q[i]);
  end

  // R6: a clear with no racing wrap removes every written bit
  a_r6_clear_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == A_OV_CLR) && (ovf_hw == '0))
      |=> ((ovf_q & $past(reg_wdata[MAP_W-1:0])) == '0));

  // R7: interrupt never asserts without a pending overflow
  a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_q != '0));

  // R8: event-reset strobe zeroes all event counters
  a_r8_zero_events: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == A_CTRL) && reg_wdata[1]) |=> (evt_cnt_flat == '0));

endmodule

bind perf_counter_bank perf_counter_bank_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_pulse(evt_pulse), .irq(irq),
  .gen_en_q(gen_en_q), .en_q(en_q), .ovf_q(ovf_q), .ovf_hw(ovf_hw),
  .evt_cnt_flat(evt_cnt_flat), .cyc_q(cyc_q)
);

// File: tb/perf_counter_bank_bench.sv
module perf_counter_bank_bench;

  localparam int NUM_EVT = 4;

  logic                  clk;
  logic                  rst_n;
  logic                  reg_wr;
  logic [11:0]           reg_addr;
  logic [63:0]           reg_wdata;
  logic [63:0]           reg_rdata;
  logic [NUM_EVT-1:0]    evt_pulse;
  logic [NUM_EVT*32-1:0] evt_select;
  logic                  irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  perf_counter_bank #(.NUM_EVT(NUM_EVT)) u_perf_counter_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .evt_select(evt_select), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_pulse(input logic [11:0] a, input logic [63:0] d,
                          input logic [NUM_EVT-1:0] m);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; evt_pulse = m;
    @(negedge clk);
    reg_wr = 1'b0; evt_pulse = '0;
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] m);
    @(negedge clk);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic expect_rd(input string req, input logic [11:0] a, input logic [63:0] exp);
    logic [63:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    expect_rd("R1 ctrl", 12'h400, 64'h2000);
    expect_rd("R1 enable map", 12'h404, 64'h0);
    expect_rd("R1 overflow map", 12'h408, 64'h0);
    expect_rd("R1 counter0", 12'h421, 64'h0);
    expect_rd("R1 cycle", 12'h40A, 64'h0);
    expect_rd("R1 type3", 12'h454, 64'h0);
    chk("R1 irq", {63'b0, irq}, 64'h0);
  endtask

  task automatic t_bitmaps;
    wr(12'h404, 64'hFFFF_FFFF);
    expect_rd("R4 set all, unimplemented zero", 12'h404, 64'h8000_000F);
    wr(12'h403, 64'h2);
    expect_rd("R4 clear one bit", 12'h404, 64'h8000_000D);
    expect_rd("R4 clear addr reads map", 12'h403, 64'h8000_000D);
    wr(12'h403, 64'hFFFF_FFFF);
    expect_rd("R4 clear all", 12'h404, 64'h0);
    wr(12'h406, 64'h5);
    wr(12'h406, 64'h2);
    expect_rd("R4 ie set accumulates", 12'h406, 64'h7);
    wr(12'h405, 64'h7);
    expect_rd("R4 ie cleared", 12'h405, 64'h0);
  endtask

  task automatic t_count;
    wr(12'h404, 64'h1);
    pulse(4'b0001); pulse(4'b0001); pulse(4'b0001);
    expect_rd("R2 no count while global off", 12'h421, 64'h0);
    wr(12'h400, 64'h1);
    expect_rd("R8 global enable reads back", 12'h400, 64'h2001);
    pulse(4'b0011); pulse(4'b0011); pulse(4'b0001);
    expect_rd("R2 enabled counter0 counts", 12'h421, 64'h3);
    expect_rd("R2 disabled counter1 idle", 12'h431, 64'h0);
    repeat (5) @(negedge clk);
    expect_rd("R2 no pulse no count", 12'h421, 64'h3);
  endtask

  task automatic t_evt_wrap;
    wr(12'h421, 64'hFFFF_FFFE);
    expect_rd("R9 preload counter0", 12'h421, 64'hFFFF_FFFE);
    pulse(4'b0001);
    expect_rd("R5 at all-ones", 12'h421, 64'hFFFF_FFFF);
    expect_rd("R5 no overflow yet", 12'h408, 64'h0);
    pulse(4'b0001);
    expect_rd("R5 wrapped to zero", 12'h421, 64'h0);
    expect_rd("R5 overflow bit0", 12'h408, 64'h1);
    chk("R7 no irq when ie clear", {63'b0, irq}, 64'h0);
    wr_pulse(12'h421, 64'h10, 4'b0001);
    expect_rd("R9 load beats increment", 12'h421, 64'h10);
  endtask

  task automatic t_cycle;
    logic [63:0] v;
    wr(12'h404, 64'h8000_0000);
    repeat (10) @(negedge clk);
    expect_rd("R3 cycle count", 12'h40A, 64'd10);
    wr(12'h40A, 64'hFFFF_FFFF_FFFF_FFFE);
    expect_rd("R9 cycle preload", 12'h40A, 64'hFFFF_FFFF_FFFF_FFFE);
    repeat (2) @(negedge clk);
    expect_rd("R5 cycle wrapped", 12'h40A, 64'h0);
    expect_rd("R5 overflow bit31", 12'h408, 64'h8000_0001);
    wr(12'h406, 64'h8000_0000);
    chk("R7 irq with bit31 enabled", {63'b0, irq}, 64'h1);
    wr(12'h403, 64'h8000_0000);
    rd(12'h408, v);
    chk("R6 status read", v, 64'h8000_0001);
    wr(12'h407, v);
    expect_rd("R6 cleared exactly", 12'h408, 64'h0);
    chk("R7 irq drops", {63'b0, irq}, 64'h0);
    wr(12'h405, 64'hFFFF_FFFF);
  endtask

  task automatic t_ovf_race;
    wr(12'h421, 64'hFFFF_FFFF);
    wr_pulse(12'h407, 64'h1, 4'b0001);
    expect_rd("R6 wrap beats clear", 12'h408, 64'h1);
    wr(12'h408, 64'h2);
    expect_rd("R6 software set", 12'h408, 64'h3);
    wr(12'h406, 64'h2);
    chk("R7 irq from bit1", {63'b0, irq}, 64'h1);
    wr(12'h407, 64'h2);
    expect_rd("R6 clear leaves bit0", 12'h408, 64'h1);
    chk("R7 irq low, bit0 not enabled", {63'b0, irq}, 64'h0);
    wr(12'h407, 64'h1);
    wr(12'h405, 64'h2);
  endtask

  task automatic t_ctrl_reset;
    wr(12'h421, 64'h5);
    wr(12'h40A, 64'h123);
    wr(12'h400, 64'h2);
    expect_rd("R8 events zeroed", 12'h421, 64'h0);
    expect_rd("R8 cycle untouched", 12'h40A, 64'h123);
    expect_rd("R8 strobes read zero", 12'h400, 64'h2000);
    wr(12'h400, 64'h4);
    expect_rd("R8 cycle zeroed", 12'h40A, 64'h0);
    wr(12'h400, 64'h1);
    expect_rd("R8 enable again", 12'h400, 64'h2001);
  endtask

  task automatic t_cfg;
    wr(12'h434, 64'hA5);
    expect_rd("R10 type1 readback", 12'h434, 64'hA5);
    chk("R10 type1 on evt_select", {32'b0, evt_select[63:32]}, 64'hA5);
    wr(12'h423, 64'h000E_0007);
    expect_rd("R10 filter0", 12'h423, 64'h000E_0007);
    wr(12'h450, 64'h3C);
    expect_rd("R10 ctl3", 12'h450, 64'h3C);
    wr(12'h409, 64'h99);
    expect_rd("R10 cycle ctl", 12'h409, 64'h99);
  endtask

  task automatic t_unmapped;
    wr(12'h410, 64'hFFFF);
    expect_rd("R11 unmapped reads zero", 12'h410, 64'h0);
    wr(12'h461, 64'h55);
    expect_rd("R11 slot beyond count", 12'h461, 64'h0);
    expect_rd("R11 hole in map", 12'h40B, 64'h0);
    expect_rd("R11 enable map untouched", 12'h404, 64'h1);
    expect_rd("R11 counter0 untouched", 12'h421, 64'h0);
    expect_rd("R11 type0 untouched", 12'h424, 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; evt_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bitmaps();
    t_count();
    t_evt_wrap();
    t_cycle();
    t_ovf_race();
    t_ctrl_reset();
    t_cfg();
    t_unmapped();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule